// File: doc/BRIEF.md
# Fetch Stage Sequencing Controller

This block is the control state machine of the instruction fetch stage in a pipelined processor. In every cycle it looks at the redirect and hold requests coming back from later stages, along with the instruction-cache miss handshake. From these it decides whether the fetch datapath may fetch, must hold, must restart at a new address, or must spend a cycle recovering. It does not build the fetch group and it does not hold the cache. It only tells the datapath when to run and where to restart.

The requests are arbitrated in a fixed order:

1. A redirect from the commit stage.
2. The reorder-buffer-busy indication.
3. A redirect from decode.
4. Any of the hold requests.
5. The controller's own state progression.

A redirect or a hold always costs one idle cycle after the request goes away before fetching resumes. A cache miss parks the stage until the refill completes, and any redirect while a miss is outstanding cancels that miss.

Top module: `fetch_seq_ctrl`

## Requirements
- R1: After reset the controller is in the running state. With all request inputs low it holds `fetch_en_o` high and `redir_valid_o`, `bp_upd_o` and `miss_cancel_o` low.
- R2: A commit redirect (`cmt_squash_i`) overrides every other input in that cycle. In the same cycle it drives `redir_valid_o` high, `redir_pc_o` equal to `cmt_pc_i`, and `redir_npc_o` equal to `cmt_pc_i + INST_BYTES` taken modulo 2^ADDR_W. It also drops `fetch_en_o` and enters the recovering state.
- R3: `bp_upd_o` is high only in a cycle where `cmt_squash_i` and `cmt_mispred_i` are both high. It carries `bp_pc_o = cmt_mispred_pc_i`, `bp_taken_o = cmt_taken_i` and `bp_target_o = cmt_pc_i`.
- R4: While `rob_busy_i` is high and no commit redirect is present, there is no fetch and no redirect, even if a decode redirect is present, and the controller enters the recovering state.
- R5: When there is no commit redirect and no `rob_busy_i`, a decode redirect (`dec_squash_i`) outside the recovering state redirects to `dec_pc_i`, with next PC `dec_pc_i + INST_BYTES`, enters recovering and does not fetch. Inside the recovering state the decode redirect produces no redirect.
- R6: If any bit of `stall_i` is high and no redirect or busy input wins, the controller does not fetch and enters the holding state, from any state including miss-wait.
- R7: In the first cycle with no stall bit high, a holding controller moves to running without fetching. It fetches in the cycle after that.
- R8: In the first cycle with no redirect, busy or stall input, a recovering controller moves to running without fetching. It fetches in the cycle after that.
- R9: `miss_i` high in a fetching cycle enters miss-wait. There is no fetch in miss-wait, including the cycle where `miss_done_i` arrives. `miss_done_i` moves the controller to miss-ready, which fetches in the next cycle.
- R10: `miss_cancel_o` pulses in a cycle where a commit or decode redirect is taken while the controller is in miss-wait. It stays low for redirects taken in any other state.
- R11: `fault_i` high in a fetching cycle enters the holding state. The next quiet cycle is idle and the one after it fetches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmt_squash_i | input | 1 | Redirect request from commit |
| cmt_pc_i | input | ADDR_W | Restart address from commit |
| cmt_mispred_i | input | 1 | Commit redirect was caused by a branch mispredict |
| cmt_mispred_pc_i | input | ADDR_W | Address of the mispredicted branch |
| cmt_taken_i | input | 1 | Resolved direction of that branch |
| rob_busy_i | input | 1 | Reorder buffer still discarding entries |
| dec_squash_i | input | 1 | Redirect request from decode |
| dec_pc_i | input | ADDR_W | Restart address from decode |
| stall_i | input | NUM_STALL | Hold requests, one per downstream stage |
| miss_i | input | 1 | Fetch in this cycle missed the instruction cache |
| miss_done_i | input | 1 | Refill for the outstanding miss has arrived |
| fault_i | input | 1 | Fetch in this cycle raised a fault |
| fetch_en_o | output | 1 | Datapath may fetch this cycle |
| redir_valid_o | output | 1 | Restart the fetch PC this cycle |
| redir_pc_o | output | ADDR_W | New fetch PC |
| redir_npc_o | output | ADDR_W | New next-PC (fetch PC plus instruction size) |
| bp_upd_o | output | 1 | Predictor training strobe |
| bp_pc_o | output | ADDR_W | Branch address to train |
| bp_taken_o | output | 1 | Direction to train |
| bp_target_o | output | ADDR_W | Target to train |
| miss_cancel_o | output | 1 | Cancel the outstanding cache miss |

## Verification
The bench builds the block with a 16-bit address, 4-byte instructions and four hold sources. The narrow address lets a redirect to the last word of the address space show the next-PC wrapping to zero. With four hold sources, each stall bit can be driven on its own, so every entry into the holding state is exercised from its own source. The chosen sizes also let the miss-wait, recovering and holding states each be entered and left in a few cycles. This keeps every one-idle-cycle exit and every miss cancellation visible at the ports.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

   typedef enum logic [2:0] {
      FS_RUN       = 3'd0,
      FS_HOLD      = 3'd1,
      FS_FLUSH     = 3'd2,
      FS_MISS_WAIT = 3'd3,
      FS_MISS_RDY  = 3'd4
   } fseq_state_e;

   typedef enum logic [1:0] {
      RSRC_NONE = 2'd0,
      RSRC_CMT  = 2'd1,
      RSRC_DEC  = 2'd2
   } fseq_rsrc_e;

endpackage

// File: rtl/fseq_hold_merge.sv
module fseq_hold_merge #(
   parameter int NUM_STALL = 4
) (
   input  logic [NUM_STALL-1:0] stall_i,
   output logic                 any_stall_o
);

   generate
      if (NUM_STALL < 1) begin : g_bad
         $error("fseq_hold_merge: NUM_STALL must be at least 1");
      end

      if (NUM_STALL == 1) begin : g_single
         assign any_stall_o = stall_i[0];
      end else begin : g_tree
         logic [NUM_STALL-1:0] acc;
         assign acc[0] = stall_i[0];
         for (genvar i = 1; i < NUM_STALL; i++) begin : g_or
            assign acc[i] = acc[i-1] | stall_i[i];
         end
         assign any_stall_o = acc[NUM_STALL-1];
      end
   endgenerate

endmodule

// File: rtl/fseq_fsm.sv
module fseq_fsm
   import fseq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmt_squash_i,
   input  logic       rob_busy_i,
   input  logic       dec_squash_i,
   input  logic       any_stall_i,
   input  logic       miss_i,
   input  logic       miss_done_i,
   input  logic       fault_i,
   output logic       fetch_en_o,
   output fseq_rsrc_e rsrc_o,
   output logic       cancel_o
);

   fseq_state_e state_q, state_d;
   logic        in_miss;

   assign in_miss = (state_q == FS_MISS_WAIT);

   always_comb begin
      state_d    = state_q;
      rsrc_o     = RSRC_NONE;
      fetch_en_o = 1'b0;
      cancel_o   = 1'b0;
      if (cmt_squash_i) begin
         rsrc_o   = RSRC_CMT;
         state_d  = FS_FLUSH;
         cancel_o = in_miss;
      end else if (rob_busy_i) begin
         state_d = FS_FLUSH;
      end else if (dec_squash_i && (state_q != FS_FLUSH)) begin
         rsrc_o   = RSRC_DEC;
         state_d  = FS_FLUSH;
         cancel_o = in_miss;
      end else if (any_stall_i) begin
         state_d = FS_HOLD;
      end else begin
         case (state_q)
            FS_HOLD, FS_FLUSH: state_d = FS_RUN;
            FS_MISS_WAIT: begin
               if (miss_done_i) state_d = FS_MISS_RDY;
            end
            default: begin
               fetch_en_o = 1'b1;
               if (fault_i)     state_d = FS_HOLD;
               else if (miss_i) state_d = FS_MISS_WAIT;
               else             state_d = FS_RUN;
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= FS_RUN;
      else        state_q <= state_d;
   end

   // R9: miss-wait never fetches
   p_miss_nofetch_r9: assert property (@(posedge clk) disable iff (!rst_n)
      in_miss |-> !fetch_en_o);

   // R11: a fault on a fetching cycle leads to holding
   p_fault_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_en_o && fault_i) |=> (state_q == FS_HOLD));

   // R5: decode redirect is never taken while recovering
   p_flush_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == FS_FLUSH) |-> (rsrc_o != RSRC_DEC));

   // R9: completion from miss-wait leads to a fetching cycle
   p_miss_rdy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_miss && miss_done_i && !cmt_squash_i && !rob_busy_i && !dec_squash_i && !any_stall_i)
      |=> (state_q == FS_MISS_RDY));

endmodule

// File: rtl/fseq_redirect.sv
module fseq_redirect
   import fseq_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int INST_BYTES = 4
) (
   input  fseq_rsrc_e        rsrc_i,
   input  logic [ADDR_W-1:0] cmt_pc_i,
   input  logic [ADDR_W-1:0] dec_pc_i,
   input  logic              cmt_mispred_i,
   input  logic [ADDR_W-1:0] cmt_mispred_pc_i,
   input  logic              cmt_taken_i,
   output logic              redir_valid_o,
   output logic [ADDR_W-1:0] redir_pc_o,
   output logic [ADDR_W-1:0] redir_npc_o,
   output logic              bp_upd_o,
   output logic [ADDR_W-1:0] bp_pc_o,
   output logic              bp_taken_o,
   output logic [ADDR_W-1:0] bp_target_o
);

   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INST_BYTES);

   generate
      if (INST_BYTES < 1 || (INST_BYTES & (INST_BYTES - 1)) != 0) begin : g_bad_size
         $error("fseq_redirect: INST_BYTES must be a power of two");
      end
      if (ADDR_W <= $clog2(INST_BYTES) + 1) begin : g_bad_width
         $error("fseq_redirect: ADDR_W too small for INST_BYTES");
      end
   endgenerate

   always_comb begin
      case (rsrc_i)
         RSRC_CMT: redir_pc_o = cmt_pc_i;
         RSRC_DEC: redir_pc_o = dec_pc_i;
         default:  redir_pc_o = '0;
      endcase
   end

   assign redir_valid_o = (rsrc_i != RSRC_NONE);
   assign redir_npc_o   = redir_pc_o + STEP;
   assign bp_upd_o      = (rsrc_i == RSRC_CMT) && cmt_mispred_i;
   assign bp_pc_o       = cmt_mispred_pc_i;
   assign bp_taken_o    = cmt_taken_i;
   assign bp_target_o   = cmt_pc_i;

endmodule

// File: rtl/fetch_seq_ctrl.sv
module fetch_seq_ctrl
   import fseq_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int INST_BYTES = 4,
   parameter int NUM_STALL  = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmt_squash_i,
   input  logic [ADDR_W-1:0]    cmt_pc_i,
   input  logic                 cmt_mispred_i,
   input  logic [ADDR_W-1:0]    cmt_mispred_pc_i,
   input  logic                 cmt_taken_i,
   input  logic                 rob_busy_i,
   input  logic                 dec_squash_i,
   input  logic [ADDR_W-1:0]    dec_pc_i,
   input  logic [NUM_STALL-1:0] stall_i,
   input  logic                 miss_i,
   input  logic                 miss_done_i,
   input  logic                 fault_i,
   output logic                 fetch_en_o,
   output logic                 redir_valid_o,
   output logic [ADDR_W-1:0]    redir_pc_o,
   output logic [ADDR_W-1:0]    redir_npc_o,
   output logic                 bp_upd_o,
   output logic [ADDR_W-1:0]    bp_pc_o,
   output logic                 bp_taken_o,
   output logic [ADDR_W-1:0]    bp_target_o,
   output logic                 miss_cancel_o
);

   logic       any_stall;
   fseq_rsrc_e rsrc;

   fseq_hold_merge #(.NUM_STALL(NUM_STALL)) u_hold (
      .stall_i     (stall_i),
      .any_stall_o (any_stall)
   );

   fseq_fsm u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .cmt_squash_i (cmt_squash_i),
      .rob_busy_i   (rob_busy_i),
      .dec_squash_i (dec_squash_i),
      .any_stall_i  (any_stall),
      .miss_i       (miss_i),
      .miss_done_i  (miss_done_i),
      .fault_i      (fault_i),
      .fetch_en_o   (fetch_en_o),
      .rsrc_o       (rsrc),
      .cancel_o     (miss_cancel_o)
   );

   fseq_redirect #(.ADDR_W(ADDR_W), .INST_BYTES(INST_BYTES)) u_redir (
      .rsrc_i           (rsrc),
      .cmt_pc_i         (cmt_pc_i),
      .dec_pc_i         (dec_pc_i),
      .cmt_mispred_i    (cmt_mispred_i),
      .cmt_mispred_pc_i (cmt_mispred_pc_i),
      .cmt_taken_i      (cmt_taken_i),
      .redir_valid_o    (redir_valid_o),
      .redir_pc_o       (redir_pc_o),
      .redir_npc_o      (redir_npc_o),
      .bp_upd_o         (bp_upd_o),
      .bp_pc_o          (bp_pc_o),
      .bp_taken_o       (bp_taken_o),
      .bp_target_o      (bp_target_o)
   );

   // R2: commit redirect wins and suppresses fetch
   p_cmt_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cmt_squash_i |-> (redir_valid_o && (redir_pc_o == cmt_pc_i) && !fetch_en_o));

   // R8: the cycle after any redirect is idle
   p_redir_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      redir_valid_o |=> !fetch_en_o);

   // R6: a hold request makes this and the next cycle idle
   p_stall_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (|stall_i) |=> !fetch_en_o);

   // R3: predictor training only on a mispredicting commit redirect
   p_bp_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
      bp_upd_o |-> (cmt_squash_i && cmt_mispred_i));

   // R10: a miss cancel only accompanies a redirect
   p_cancel_redir_r10: assert property (@(posedge clk) disable iff (!rst_n)
      miss_cancel_o |-> redir_valid_o);

endmodule

// File: tb/sim_fetch_seq_ctrl.sv
module sim_fetch_seq_ctrl;

   localparam int AW = 16;
   localparam int IB = 4;
   localparam int NS = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmt_squash_i, cmt_mispred_i, cmt_taken_i, rob_busy_i, dec_squash_i;
   logic [AW-1:0] cmt_pc_i, cmt_mispred_pc_i, dec_pc_i;
   logic [NS-1:0] stall_i;
   logic          miss_i, miss_done_i, fault_i;
   logic          fetch_en_o, redir_valid_o, bp_upd_o, bp_taken_o, miss_cancel_o;
   logic [AW-1:0] redir_pc_o, redir_npc_o, bp_pc_o, bp_target_o;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   fetch_seq_ctrl #(.ADDR_W(AW), .INST_BYTES(IB), .NUM_STALL(NS)) u0 (
      .clk(clk), .rst_n(rst_n),
      .cmt_squash_i(cmt_squash_i), .cmt_pc_i(cmt_pc_i), .cmt_mispred_i(cmt_mispred_i),
      .cmt_mispred_pc_i(cmt_mispred_pc_i), .cmt_taken_i(cmt_taken_i),
      .rob_busy_i(rob_busy_i), .dec_squash_i(dec_squash_i), .dec_pc_i(dec_pc_i),
      .stall_i(stall_i), .miss_i(miss_i), .miss_done_i(miss_done_i), .fault_i(fault_i),
      .fetch_en_o(fetch_en_o), .redir_valid_o(redir_valid_o), .redir_pc_o(redir_pc_o),
      .redir_npc_o(redir_npc_o), .bp_upd_o(bp_upd_o), .bp_pc_o(bp_pc_o),
      .bp_taken_o(bp_taken_o), .bp_target_o(bp_target_o), .miss_cancel_o(miss_cancel_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic clr();
      cmt_squash_i = 0; cmt_mispred_i = 0; cmt_taken_i = 0; rob_busy_i = 0;
      dec_squash_i = 0; cmt_pc_i = '0; cmt_mispred_pc_i = '0; dec_pc_i = '0;
      stall_i = '0; miss_i = 0; miss_done_i = 0; fault_i = 0;
   endtask

   // advance one clock; inputs may change afterwards
   task automatic nxt();
      @(posedge clk);
      #2;
   endtask

   // let combinational outputs settle
   task automatic look();
      #2;
   endtask

   task automatic t_reset();
      clr(); look();
      chk("R1 fetch_en", fetch_en_o, 1);
      chk("R1 redir_valid", redir_valid_o, 0);
      chk("R1 bp_upd", bp_upd_o, 0);
      chk("R1 miss_cancel", miss_cancel_o, 0);
   endtask

   task automatic t_cmt_squash();
      cmt_squash_i = 1; cmt_pc_i = 16'h1000; dec_squash_i = 1; dec_pc_i = 16'h2000;
      stall_i = 4'b0001; look();
      chk("R2 redir_valid", redir_valid_o, 1);
      chk("R2 redir_pc", redir_pc_o, 16'h1000);
      chk("R2 redir_npc", redir_npc_o, 16'h1004);
      chk("R2 fetch_en", fetch_en_o, 0);
      chk("R3 no bp_upd", bp_upd_o, 0);
      chk("R10 no cancel", miss_cancel_o, 0);
      nxt(); clr(); look();
      chk("R8 idle exit", fetch_en_o, 0);
      nxt(); look();
      chk("R8 resume", fetch_en_o, 1);
      cmt_squash_i = 1; cmt_pc_i = 16'hFFFC; look();
      chk("R2 npc wrap", redir_npc_o, 16'h0000);
      nxt(); clr(); nxt(); look();
      chk("R8 resume after wrap", fetch_en_o, 1);
   endtask

   task automatic t_mispredict();
      cmt_squash_i = 1; cmt_pc_i = 16'h0400; cmt_mispred_i = 1;
      cmt_mispred_pc_i = 16'h0300; cmt_taken_i = 1; look();
      chk("R3 bp_upd", bp_upd_o, 1);
      chk("R3 bp_pc", bp_pc_o, 16'h0300);
      chk("R3 bp_taken", bp_taken_o, 1);
      chk("R3 bp_target", bp_target_o, 16'h0400);
      nxt(); clr(); cmt_mispred_i = 1; look();
      chk("R3 no bp_upd without squash", bp_upd_o, 0);
      nxt(); clr(); look();
      chk("R8 resume after mispredict", fetch_en_o, 1);
   endtask

   task automatic t_rob_and_decode();
      rob_busy_i = 1; dec_squash_i = 1; dec_pc_i = 16'h0500; look();
      chk("R4 fetch_en", fetch_en_o, 0);
      chk("R4 no redirect", redir_valid_o, 0);
      nxt(); clr(); rob_busy_i = 1; look();
      chk("R4 held busy", fetch_en_o, 0);
      nxt(); clr(); dec_squash_i = 1; dec_pc_i = 16'h0500; look();
      chk("R5 ignored while recovering", redir_valid_o, 0);
      chk("R8 idle exit", fetch_en_o, 0);
      nxt(); clr(); look();
      chk("R8 resume", fetch_en_o, 1);
      dec_squash_i = 1; dec_pc_i = 16'h0500; look();
      chk("R5 redir_valid", redir_valid_o, 1);
      chk("R5 redir_pc", redir_pc_o, 16'h0500);
      chk("R5 redir_npc", redir_npc_o, 16'h0504);
      chk("R5 fetch_en", fetch_en_o, 0);
      nxt(); clr(); look();
      chk("R8 idle after decode redirect", fetch_en_o, 0);
      nxt(); look();
      chk("R8 resume after decode redirect", fetch_en_o, 1);
   endtask

   task automatic t_stall();
      for (int i = 0; i < NS; i++) begin
         clr(); stall_i[i] = 1'b1; look();
         chk("R6 stall fetch_en", fetch_en_o, 0);
         nxt(); look();
         chk("R6 held", fetch_en_o, 0);
         nxt(); clr(); look();
         chk("R7 idle exit", fetch_en_o, 0);
         nxt(); look();
         chk("R7 resume", fetch_en_o, 1);
      end
   endtask

   task automatic t_miss();
      miss_i = 1; look();
      chk("R9 fetch on miss cycle", fetch_en_o, 1);
      nxt(); clr(); look();
      chk("R9 wait", fetch_en_o, 0);
      nxt(); look();
      chk("R9 still wait", fetch_en_o, 0);
      miss_done_i = 1; look();
      chk("R9 done cycle idle", fetch_en_o, 0);
      nxt(); clr(); look();
      chk("R9 ready fetch", fetch_en_o, 1);
      nxt(); look();
      chk("R9 back to run", fetch_en_o, 1);
      // stall during miss-wait goes to holding
      miss_i = 1; nxt(); clr(); stall_i = 4'b1000; look();
      chk("R6 stall in miss", fetch_en_o, 0);
      nxt(); clr(); look();
      chk("R7 idle exit from miss stall", fetch_en_o, 0);
      nxt(); look();
      chk("R6 left miss-wait", fetch_en_o, 1);
   endtask

   task automatic t_cancel();
      miss_i = 1; nxt(); clr(); look();
      chk("R10 quiet no cancel", miss_cancel_o, 0);
      dec_squash_i = 1; dec_pc_i = 16'h0600; look();
      chk("R10 cancel on decode", miss_cancel_o, 1);
      chk("R10 redirect on decode", redir_valid_o, 1);
      nxt(); clr(); nxt(); look();
      chk("R8 resume after cancel", fetch_en_o, 1);
      miss_i = 1; nxt(); clr(); cmt_squash_i = 1; cmt_pc_i = 16'h0700; look();
      chk("R10 cancel on commit", miss_cancel_o, 1);
      nxt(); clr(); nxt(); look();
      cmt_squash_i = 1; cmt_pc_i = 16'h0800; look();
      chk("R10 no cancel in run", miss_cancel_o, 0);
      nxt(); clr(); nxt(); look();
      chk("R8 resume", fetch_en_o, 1);
   endtask

   task automatic t_fault();
      fault_i = 1; look();
      chk("R11 fetch on fault cycle", fetch_en_o, 1);
      nxt(); clr(); look();
      chk("R11 idle after fault", fetch_en_o, 0);
      nxt(); look();
      chk("R11 resume", fetch_en_o, 1);
   endtask

   initial begin
      clr();
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      nxt();
      t_reset();
      t_cmt_squash();
      t_mispredict();
      t_rob_and_decode();
      t_stall();
      t_miss();
      t_cancel();
      t_fault();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_err++;
         $display("FAIL watchdog all actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule